// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block connects a CPU-side operand request to a 16-bit external data bus whose devices may be either 8 or 16 bits wide. A request names an address, an operand size (one, two or four bytes), a direction and, for writes, the operand. The sequencer runs one or more external bus cycles to move it. Each cycle opens as though the device were 16 bits wide and moves as many bytes as that allows. The device ends each cycle with a two-bit acknowledge code. That code also tells the sequencer the device's port width, so the sequencer knows how many bytes actually moved and what is still left to transfer.

Bytes move most significant first. Between partial cycles the sequencer advances the address and lowers the size code it presents. When the last byte has moved, it returns the read operand right-justified together with a one-clock done pulse. A reserved acknowledge code aborts the transfer and raises an error flag alongside the done pulse. Operands are assumed to be naturally aligned: word and long-word requests use even addresses.

Top module: `dbs_seq`

## Requirements
- R1: While reset is high, and afterwards until a request arrives, `bus_strb`, `busy`, `rsp_done` and `rsp_err` are low and `rsp_rdata` is zero.
- R2: While `bus_dsack` is 11 during a cycle, the cycle is held open: `bus_strb` stays high and `bus_addr`, `bus_siz` and `bus_dout` do not change until a different code arrives.
- R3: Code 10 completes a cycle as an 8-bit port. Exactly one byte moves, on `bus_din[15:8]` or `bus_dout[15:8]`, so a word needs 2 cycles and a long word needs 4.
- R4: Code 01 completes a cycle as a 16-bit port. At an even address with two or more bytes left, two bytes move: the earlier byte on [15:8] and the later on [7:0]. Otherwise one byte moves, on [7:0] at an odd address and on [15:8] at an even one. A long word therefore needs 2 cycles and a word or a byte needs 1.
- R5: The first cycle of a transfer presents the request address and the full operand size. It assumes a 16-bit port.
- R6: After each completed cycle, the address advances by the number of bytes moved. `bus_siz` then equals the number of bytes still left, modulo 4 (01 = one, 10 = two, 11 = three, 00 = four).
- R7: `req_size` encodes 01 = byte, 10 = word, 00 = long word. Read bytes are assembled most significant first and returned right-justified in `rsp_rdata` with the unused upper bits zero.
- R8: Whenever a single byte is driven (one byte left, or an odd address), it appears on both `bus_dout[15:8]` and `bus_dout[7:0]`, so an 8-bit port always finds each written byte on [15:8].
- R9: Code 00 ends the transfer at once. `rsp_done` and `rsp_err` pulse together for one clock, and the strobe drops.
- R10: `rsp_done` lasts exactly one clock, with `busy` and `bus_strb` low in that clock. A `req_valid` seen while `busy` is high has no effect on the running transfer.
- R11: After every completed cycle, `bus_strb` is low for at least one clock before the next cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transfer (taken only while idle) |
| req_addr | input | ADDR_W | Operand start address |
| req_size | input | 2 | Operand size: 01 byte, 10 word, 00 long word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | A transfer is in progress |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Reserved acknowledge seen (with rsp_done) |
| rsp_rdata | output | 32 | Assembled read operand, right-justified |
| bus_strb | output | 1 | Bus cycle active |
| bus_wr | output | 1 | Direction of the current cycle, 1 = write |
| bus_addr | output | ADDR_W | Address of the current cycle |
| bus_siz | output | 2 | Bytes left in the transfer, modulo 4 |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_dsack | input | 2 | Acknowledge: 11 wait, 10 8-bit, 01 16-bit, 00 reserved |

## Verification
The bench sweeps every operand size, direction and legal offset against two modelled devices, one 8 bits wide and one 16 bits wide, each with and without wait states. It targets the transitions where the lane choice changes. A design that ignored the address parity would read the wrong half of a 16-bit word for odd bytes. A design that failed to replicate single bytes would leave an 8-bit device holding stale data after an odd-address write. A design that kept the first cycle's width instead of re-deciding it per acknowledge would miscount cycles or skip bytes on the 8-bit port. Separate runs hold the cycle open with long wait runs, return the reserved code, and raise a new request mid-transfer. These expose a design that drifts its address during waits, hangs on the error, or restarts on a second request.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int OP_W    = 32;
  localparam int LANE_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int OP_BYTES = OP_W / BYTE_W;
  localparam int CNT_W   = $clog2(OP_BYTES + 1);

  typedef enum logic [1:0] {
    ACK_RSVD = 2'b00,
    ACK_P16  = 2'b01,
    ACK_P8   = 2'b10,
    ACK_WAIT = 2'b11
  } ack_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_GAP
  } st_e;

  // operand size code to byte count (00 encodes the full operand)
  function automatic logic [CNT_W-1:0] size_bytes(input logic [1:0] sz);
    if (sz == 2'b00) return CNT_W'(OP_BYTES);
    return CNT_W'(sz);
  endfunction

endpackage

// File: rtl/dbs_step.sv
// Decodes one acknowledge: whether the cycle ended, how many bytes moved
// and which lanes carried them.
module dbs_step
  import dbs_pkg::*;
(
  input  ack_e              ack,
  input  logic              addr_lsb,
  input  logic [CNT_W-1:0]  left,
  input  logic [LANE_W-1:0] din,
  output logic              fin,
  output logic              bad,
  output logic              two,
  output logic [BYTE_W-1:0] b_first,
  output logic [BYTE_W-1:0] b_second
);

  always_comb begin
    fin      = 1'b0;
    bad      = 1'b0;
    two      = 1'b0;
    b_first  = din[LANE_W-1 -: BYTE_W];
    b_second = din[BYTE_W-1:0];
    case (ack)
      ACK_P8: begin
        fin = 1'b1;
      end
      ACK_P16: begin
        fin = 1'b1;
        if (addr_lsb) begin
          b_first = din[BYTE_W-1:0];
        end else if (left >= CNT_W'(2)) begin
          two = 1'b1;
        end
      end
      ACK_RSVD: begin
        bad = 1'b1;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/dbs_lane_mux.sv
// Places outgoing write bytes on the data lanes.
module dbs_lane_mux
  import dbs_pkg::*;
(
  input  logic [LANE_W-1:0] head,
  input  logic              addr_lsb,
  input  logic [CNT_W-1:0]  left,
  output logic [LANE_W-1:0] dout
);

  logic pair;

  assign pair = (left >= CNT_W'(2)) && !addr_lsb;

  always_comb begin
    if (pair) begin
      dout = head;
    end else begin
      dout = {head[LANE_W-1 -: BYTE_W], head[LANE_W-1 -: BYTE_W]};
    end
  end

endmodule

// File: rtl/dbs_rd_pack.sv
// Collects read bytes, most significant first, into a right-justified word.
module dbs_rd_pack
  import dbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              two,
  input  logic [BYTE_W-1:0] b_first,
  input  logic [BYTE_W-1:0] b_second,
  output logic [OP_W-1:0]   acc_next
);

  logic [OP_W-1:0] acc_q;

  always_comb begin
    if (two) begin
      acc_next = {acc_q[OP_W-2*BYTE_W-1:0], b_first, b_second};
    end else begin
      acc_next = {acc_q[OP_W-BYTE_W-1:0], b_first};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_next;
    end
  end

endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              bus_strb,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic [15:0]       bus_dout,
  input  logic [15:0]       bus_din,
  input  logic [1:0]        bus_dsack
);

  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              wr_q;
  logic [OP_W-1:0]   wsh_q;
  logic              strb_q;
  logic              done_q;
  logic              err_q;
  logic [OP_W-1:0]   rdata_q;

  logic              fin;
  logic              bad;
  logic              two;
  logic [BYTE_W-1:0] b_first;
  logic [BYTE_W-1:0] b_second;
  logic [OP_W-1:0]   acc_next;
  logic [CNT_W-1:0]  nbytes;
  logic [CNT_W-1:0]  left_n;
  logic [CNT_W-1:0]  req_n;
  logic              take;
  logic              step;

  assign take   = (st_q == ST_IDLE) && req_valid;
  assign step   = (st_q == ST_ACT) && fin;
  assign nbytes = two ? CNT_W'(2) : CNT_W'(1);
  assign left_n = left_q - nbytes;
  assign req_n  = size_bytes(req_size);

  dbs_step u_step (
    .ack      (ack_e'(bus_dsack)),
    .addr_lsb (addr_q[0]),
    .left     (left_q),
    .din      (bus_din),
    .fin      (fin),
    .bad      (bad),
    .two      (two),
    .b_first  (b_first),
    .b_second (b_second)
  );

  dbs_lane_mux u_lane (
    .head     (wsh_q[OP_W-1 -: LANE_W]),
    .addr_lsb (addr_q[0]),
    .left     (left_q),
    .dout     (bus_dout)
  );

  dbs_rd_pack u_pack (
    .clk      (clk),
    .rst      (rst),
    .clr      (take),
    .en       (step),
    .two      (two),
    .b_first  (b_first),
    .b_second (b_second),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      wsh_q   <= '0;
      strb_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            left_q <= req_n;
            wr_q   <= req_write;
            wsh_q  <= req_wdata << {(CNT_W'(OP_BYTES) - req_n), 3'b000};
            strb_q <= 1'b1;
            st_q   <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (bad) begin
            strb_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (fin) begin
            addr_q <= addr_q + ADDR_W'(nbytes);
            left_q <= left_n;
            wsh_q  <= two ? (wsh_q << (2 * BYTE_W)) : (wsh_q << BYTE_W);
            strb_q <= 1'b0;
            if (left_n == '0) begin
              done_q  <= 1'b1;
              rdata_q <= acc_next;
              st_q    <= ST_IDLE;
            end else begin
              st_q <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          strb_q <= 1'b1;
          st_q   <= ST_ACT;
        end
        default: begin
          st_q   <= ST_IDLE;
          strb_q <= 1'b0;
        end
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign bus_strb  = strb_q;
  assign bus_wr    = wr_q;
  assign bus_addr  = addr_q;
  assign bus_siz   = left_q[1:0];

endmodule

// File: rtl/dbs_seq_chk.sv
module dbs_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              bus_strb,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic [15:0]       bus_dout,
  input logic [1:0]        bus_dsack
);

  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strb && bus_dsack == 2'b11) |=>
      (bus_strb && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout)));

  // R8
  lane_dup_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strb && bus_wr && (bus_siz == 2'b01 || bus_addr[0])) |->
      (bus_dout[15:8] == bus_dout[7:0]));

  // R9
  rsvd_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strb && bus_dsack == 2'b00) |=> (rsp_done && rsp_err && !bus_strb));

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (!busy && !bus_strb));

  // R11
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_strb && (bus_dsack == 2'b10 || bus_dsack == 2'b01)) |=> !bus_strb);

  // R1
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_strb |-> busy);

endmodule

bind dbs_seq dbs_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .bus_strb  (bus_strb),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_siz   (bus_siz),
  .bus_dout  (bus_dout),
  .bus_dsack (bus_dsack)
);

// File: tb/sim_dbs_seq.sv
`timescale 1ns/1ps
module sim_dbs_seq;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'b01;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          busy, rsp_done, rsp_err, bus_strb, bus_wr;
  logic [31:0]   rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din = '0;
  logic [1:0]    bus_dsack = 2'b11;

  always #2.5 clk = ~clk;

  dbs_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_strb(bus_strb), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_dsack(bus_dsack)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]    mem [0:31];
  int            waits = 0;
  bit            err_mode = 0;
  int            ncyc = 0;
  int            wcnt = 0;
  bit            acked = 0;
  logic [AW-1:0] exp_addr = '0;
  int            exp_left = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // device model: address bit 4 selects the 8-bit port
  always @(negedge clk) begin
    if (rst) begin
      bus_dsack = 2'b11;
      wcnt = 0;
      acked = 0;
    end else begin
      if (acked) begin
        chk(!bus_strb, "R11 strobe low after cycle", 32'(bus_strb), 32'd0);
        acked = 0;
      end
      if (!bus_strb) begin
        bus_dsack = 2'b11;
        wcnt = 0;
      end else begin
        if (wcnt == 0) begin
          ncyc++;
          chk(bus_addr == exp_addr, (ncyc == 1) ? "R5 first address" : "R6 address advance",
              32'(bus_addr), 32'(exp_addr));
          chk(bus_siz == 2'(exp_left), (ncyc == 1) ? "R5 first size code" : "R6 size code",
              32'(bus_siz), 32'(exp_left & 3));
        end else begin
          chk(bus_addr == exp_addr && bus_siz == 2'(exp_left), "R2 held during wait",
              32'(bus_addr), 32'(exp_addr));
        end
        if (wcnt < waits) begin
          bus_dsack = 2'b11;
          wcnt++;
        end else begin
          int a;
          int moved;
          a = int'(bus_addr[4:0]);
          moved = 1;
          if (bus_wr && (bus_siz == 2'b01 || a[0]))
            chk(bus_dout[15:8] == bus_dout[7:0], "R8 byte on both lanes",
                32'(bus_dout), {16'd0, bus_dout[15:8], bus_dout[15:8]});
          if (err_mode) begin
            bus_dsack = 2'b00;
          end else if (bus_addr[4]) begin
            bus_dsack = 2'b10;
            bus_din = {mem[a], 8'h5A};
            if (bus_wr) mem[a] = bus_dout[15:8];
          end else begin
            bus_dsack = 2'b01;
            bus_din = {mem[a & ~1], mem[a | 1]};
            if (a[0] || bus_siz == 2'b01) begin
              if (bus_wr) mem[a] = a[0] ? bus_dout[7:0] : bus_dout[15:8];
            end else begin
              moved = 2;
              if (bus_wr) begin
                mem[a] = bus_dout[15:8];
                mem[a + 1] = bus_dout[7:0];
              end
            end
          end
          exp_addr = exp_addr + AW'(moved);
          exp_left = exp_left - moved;
          acked = 1;
          wcnt++;
        end
      end
    end
  end

  task automatic wait_done(output bit seen);
    int t;
    t = 0;
    while (!rsp_done && t < 300) begin
      @(negedge clk);
      t++;
    end
    seen = rsp_done;
  endtask

  task automatic xfer(input int addr, input int n, input bit wr,
                      input logic [31:0] wd, input int w, input bit poke);
    bit seen;
    bit p8;
    int exp_cyc;
    logic [31:0] exp_rd;
    waits = w;
    err_mode = 0;
    for (int i = 0; i < 32; i++) mem[i] = pat(i);
    exp_addr = AW'(addr);
    exp_left = n;
    ncyc = 0;
    p8 = (addr & 16) != 0;
    exp_cyc = p8 ? n : ((n == 4) ? 2 : 1);
    exp_rd = '0;
    for (int k = 0; k < n; k++) exp_rd = (exp_rd << 8) | 32'(pat(addr + k));
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = AW'(addr);
    req_size = (n == 4) ? 2'b00 : 2'(n);
    req_write = wr;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R10: a second request while busy must be ignored
      @(negedge clk);
      req_valid = 1'b1;
      req_addr = AW'(addr ^ 5);
      req_size = 2'b01;
      req_write = ~wr;
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_done(seen);
    chk(seen, "R10 done pulse seen", 32'(seen), 32'd1);
    chk(!rsp_err, "R9 no error on legal codes", 32'(rsp_err), 32'd0);
    chk(ncyc == exp_cyc, p8 ? "R3 cycle count 8-bit port" : "R4 cycle count 16-bit port",
        32'(ncyc), 32'(exp_cyc));
    if (!wr) begin
      chk(rsp_rdata == exp_rd, "R7 read data", rsp_rdata, exp_rd);
    end else begin
      for (int k = 0; k < n; k++) begin
        logic [7:0] eb;
        eb = 8'(wd >> (8 * (n - 1 - k)));
        chk(mem[addr + k] == eb, p8 ? "R8 written byte 8-bit port" : "R4 written byte 16-bit port",
            32'(mem[addr + k]), 32'(eb));
      end
      if ((addr & 15) != 0)
        chk(mem[addr - 1] == pat(addr - 1), "R6 byte below untouched",
            32'(mem[addr - 1]), 32'(pat(addr - 1)));
      if (((addr + n) & 15) != 0)
        chk(mem[addr + n] == pat(addr + n), "R6 byte above untouched",
            32'(mem[addr + n]), 32'(pat(addr + n)));
    end
    @(negedge clk);
    chk(!rsp_done && !busy && !bus_strb, "R10 done lasts one clock then idle",
        {29'd0, rsp_done, busy, bus_strb}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_strb && !busy && !rsp_done && !rsp_err, "R1 outputs low in reset",
        {28'd0, bus_strb, busy, rsp_done, rsp_err}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!bus_strb && !busy && rsp_rdata == 32'd0, "R1 idle after reset",
        rsp_rdata, 32'd0);

    for (int w = 0; w < 3; w += 2) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int base = 8; base < 32; base += 16) begin
          for (int off = 0; off < 4; off++)
            xfer(base + off, 1, wr[0], 32'h0000_00C0 + 32'(off * 17 + base), w, 0);
          for (int off = 0; off < 4; off += 2)
            xfer(base + off, 2, wr[0], 32'h0000_B1E0 + 32'(off + base), w, 0);
          xfer(base + 4, 4, wr[0], 32'hF0E1_D2C3 ^ 32'(base), w, 0);
        end
      end
    end

    // R2 long wait runs on both ports
    xfer(24, 4, 0, 32'd0, 6, 0);
    xfer(10, 2, 1, 32'h0000_9A7B, 5, 0);

    // R10 request while busy ignored
    xfer(20, 4, 0, 32'd0, 1, 1);
    xfer(12, 4, 1, 32'h1357_9BDF, 1, 1);

    // R9 reserved acknowledge
    waits = 1;
    err_mode = 1;
    ncyc = 0;
    exp_addr = AW'(8);
    exp_left = 4;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = AW'(8);
    req_size = 2'b00;
    req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(seen);
    chk(seen && rsp_err, "R9 reserved code gives done with error",
        {30'd0, seen, rsp_err}, 32'd3);
    chk(ncyc == 1, "R9 transfer ends after one cycle", 32'(ncyc), 32'd1);
    @(negedge clk);
    chk(!rsp_err && !rsp_done && !busy && !bus_strb, "R9 back to idle after error",
        {28'd0, rsp_err, rsp_done, busy, bus_strb}, 32'd0);
    err_mode = 0;
    repeat (3) @(negedge clk);
    chk(!bus_strb && !busy, "R10 no cycle without request",
        {30'd0, bus_strb, busy}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule